// File: doc/BRIEF.md
# Byte Shift, Rotate and Bit-Field Unit

This unit is the execution slice for the prefixed bit-manipulation group of an 8-bit accumulator CPU. The sequencer presents one byte operand, the current flag nibble, an operation code and a bit index together with a valid strobe. One clock later the unit returns the new byte, a write enable for the destination, and the updated zero, subtract, half-carry and carry flags.

It covers four rotate kinds, three shift kinds, nibble swap, and single-bit test, clear and set. It also covers the short accumulator rotate forms, which differ only in their zero-flag rule. Operand fetch, write-back routing, decode and multi-cycle sequencing stay with the caller.

Flags travel as a 4-bit vector with Z at bit 3, N at bit 2, H at bit 1 and C at bit 0. Operations that leave a flag unchanged copy it from `flags_i`.

Top module: `byte_bitop_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `wr_en_o`, `result_o` and `flags_o` are all zero.
- R2: Rotate left through carry (op 2, and its accumulator form op 13) gives result bit 0 = incoming C, result bit k = operand bit k-1, and new C = operand bit 7.
- R3: Plain rotate left (op 0, accumulator form op 11) copies operand bit 7 into both result bit 0 and C. The other bits move up one place.
- R4: Plain rotate right (op 1, accumulator form op 12) copies operand bit 0 into result bit 7 and C. Rotate right through carry (op 3, accumulator form op 14) puts the incoming C in bit 7 and operand bit 0 in C.
- R5: Arithmetic shift left (op 4) inserts 0 at bit 0 and sends operand bit 7 to C.
- R6: Arithmetic shift right (op 5) keeps bit 7 and sends bit 0 to C. Logical shift right (op 7) inserts 0 at bit 7 and sends bit 0 to C.
- R7: Swap (op 6) exchanges the two 4-bit halves and clears C.
- R8: For ops 0 to 7, Z is set exactly when the result is zero, N and H are cleared, and the result is written.
- R9: The accumulator forms (ops 11 to 14) always clear Z, clear N and H, and write the result.
- R10: Bit test (op 8) sets Z when operand bit `bit_idx_i` is 0, where index 0 is the rightmost bit. It sets H, clears N, keeps C, does not write, and returns the operand unchanged on `result_o`.
- R11: Bit clear (op 9) and bit set (op 10) force the indexed bit to 0 or 1, write the result, and leave all four flags unchanged.
- R12: Outputs are registered once: a request accepted at one edge appears after that edge. Without `valid_i`, `valid_o` and `wr_en_o` are 0 and `result_o` and `flags_o` hold.
- R13: Op code 15 is accepted (`valid_o` = 1) but does not write. It returns the operand and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| bit_idx_i | input | 3 | Bit index for test, clear and set |
| operand_i | input | 8 | Byte operand |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| valid_o | output | 1 | Registered result valid |
| result_o | output | 8 | Registered result byte |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Registered flags {Z,N,H,C} |

## Verification
On every cycle the assertions check several properties across the register stage. Bit test never writes and keeps C. Clear and set pass the flags through. Swap clears N, H and C. The accumulator rotates clear Z. Left-going ops take C from operand bit 7, and an idle cycle produces no write. The exact result bytes for each op follow from the bench's arithmetic reference model compared each clock. So do the index-to-bit mapping at the extremes, the sign-keeping right shift, and the holding of outputs through idle gaps. Those can only be shown by the bench's scenarios.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [3:0] {
    OP_RLC  = 4'd0,
    OP_RRC  = 4'd1,
    OP_RL   = 4'd2,
    OP_RR   = 4'd3,
    OP_SLA  = 4'd4,
    OP_SRA  = 4'd5,
    OP_SWAP = 4'd6,
    OP_SRL  = 4'd7,
    OP_BIT  = 4'd8,
    OP_RES  = 4'd9,
    OP_SET  = 4'd10,
    OP_RLCA = 4'd11,
    OP_RRCA = 4'd12,
    OP_RLA  = 4'd13,
    OP_RRA  = 4'd14,
    OP_NONE = 4'd15
  } op_e;

  localparam int F_Z = 3;
  localparam int F_N = 2;
  localparam int F_H = 1;
  localparam int F_C = 0;
  localparam int FLAG_W = 4;
endpackage

// File: rtl/bitop_rotshift.sv
module bitop_rotshift
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              hit_o,
  output logic              acc_o
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    res_o   = data_i;
    carry_o = carry_i;
    hit_o   = 1'b1;
    acc_o   = 1'b0;
    case (op_i)
      OP_RLC, OP_RLCA: begin
        res_o   = {data_i[DATA_W-2:0], data_i[DATA_W-1]};
        carry_o = data_i[DATA_W-1];
        acc_o   = (op_i == OP_RLCA);
      end
      OP_RRC, OP_RRCA: begin
        res_o   = {data_i[0], data_i[DATA_W-1:1]};
        carry_o = data_i[0];
        acc_o   = (op_i == OP_RRCA);
      end
      OP_RL, OP_RLA: begin
        res_o   = {data_i[DATA_W-2:0], carry_i};
        carry_o = data_i[DATA_W-1];
        acc_o   = (op_i == OP_RLA);
      end
      OP_RR, OP_RRA: begin
        res_o   = {carry_i, data_i[DATA_W-1:1]};
        carry_o = data_i[0];
        acc_o   = (op_i == OP_RRA);
      end
      OP_SLA: begin
        res_o   = {data_i[DATA_W-2:0], 1'b0};
        carry_o = data_i[DATA_W-1];
      end
      OP_SRA: begin
        res_o   = {data_i[DATA_W-1], data_i[DATA_W-1:1]};
        carry_o = data_i[0];
      end
      OP_SRL: begin
        res_o   = {1'b0, data_i[DATA_W-1:1]};
        carry_o = data_i[0];
      end
      OP_SWAP: begin
        res_o   = {data_i[HALF-1:0], data_i[DATA_W-1:HALF]};
        carry_o = 1'b0;
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bitop_bitfield.sv
module bitop_bitfield #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              set_i,
  output logic [DATA_W-1:0] res_o,
  output logic              bit_o
);
  logic [DATA_W-1:0] sel;

  for (genvar i = 0; i < DATA_W; i++) begin : g_sel
    assign sel[i] = (idx_i == IDX_W'(i));
  end

  assign res_o = set_i ? (data_i | sel) : (data_i & ~sel);
  assign bit_o = |(data_i & sel);
endmodule

// File: rtl/byte_bitop_unit.sv
module byte_bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [3:0]           op_i,
  input  logic [IDX_W-1:0]     bit_idx_i,
  input  logic [DATA_W-1:0]    operand_i,
  input  logic [FLAG_W-1:0]    flags_i,
  output logic                 valid_o,
  output logic [DATA_W-1:0]    result_o,
  output logic                 wr_en_o,
  output logic [FLAG_W-1:0]    flags_o
);
  op_e               op;
  logic [DATA_W-1:0] rs_res, bf_res, nxt_res;
  logic              rs_c, rs_hit, rs_acc, bf_bit, nxt_wr;
  logic [FLAG_W-1:0] nxt_f;

  assign op = op_e'(op_i);

  bitop_rotshift #(.DATA_W(DATA_W)) u_rs (
    .op_i    (op),
    .data_i  (operand_i),
    .carry_i (flags_i[F_C]),
    .res_o   (rs_res),
    .carry_o (rs_c),
    .hit_o   (rs_hit),
    .acc_o   (rs_acc)
  );

  bitop_bitfield #(.DATA_W(DATA_W)) u_bf (
    .idx_i  (bit_idx_i),
    .data_i (operand_i),
    .set_i  (op == OP_SET),
    .res_o  (bf_res),
    .bit_o  (bf_bit)
  );

  always_comb begin
    nxt_res = operand_i;
    nxt_wr  = 1'b0;
    nxt_f   = flags_i;
    if (rs_hit) begin
      nxt_res      = rs_res;
      nxt_wr       = 1'b1;
      nxt_f[F_Z]   = ~rs_acc & (rs_res == '0);
      nxt_f[F_N]   = 1'b0;
      nxt_f[F_H]   = 1'b0;
      nxt_f[F_C]   = rs_c;
    end else if (op == OP_BIT) begin
      nxt_f[F_Z]   = ~bf_bit;
      nxt_f[F_N]   = 1'b0;
      nxt_f[F_H]   = 1'b1;
    end else if (op == OP_RES || op == OP_SET) begin
      nxt_res      = bf_res;
      nxt_wr       = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i & nxt_wr;
      if (valid_i) begin
        result_o <= nxt_res;
        flags_o  <= nxt_f;
      end
    end
  end
endmodule

// File: rtl/byte_bitop_unit_chk.sv
module byte_bitop_unit_chk
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [3:0]           op_i,
  input logic [IDX_W-1:0]     bit_idx_i,
  input logic [DATA_W-1:0]    operand_i,
  input logic [FLAG_W-1:0]    flags_i,
  input logic                 valid_o,
  input logic [DATA_W-1:0]    result_o,
  input logic                 wr_en_o,
  input logic [FLAG_W-1:0]    flags_o
);
  logic is_acc, is_left;
  assign is_acc  = valid_i && (op_i >= 4'(OP_RLCA)) && (op_i <= 4'(OP_RRA));
  assign is_left = valid_i && (op_i == 4'(OP_RL) || op_i == 4'(OP_RLC) || op_i == 4'(OP_SLA) ||
                               op_i == 4'(OP_RLA) || op_i == 4'(OP_RLCA));

  AST_BIT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'(OP_BIT)) |=> (!wr_en_o && flags_o[F_H] && !flags_o[F_N] &&
      flags_o[F_C] == $past(flags_i[F_C]))); // R10
  AST_RESSET_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'(OP_RES) || op_i == 4'(OP_SET))) |=> (wr_en_o && flags_o == $past(flags_i))); // R11
  AST_SWAP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'(OP_SWAP)) |=> (flags_o[F_N:F_C] == 3'b000)); // R7
  AST_ACC_NO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_acc |=> (!flags_o[F_Z] && wr_en_o)); // R9
  AST_LEFT_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_left |=> (flags_o[F_C] == $past(operand_i[DATA_W-1]))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !wr_en_o && $stable(result_o) && $stable(flags_o))); // R12
  AST_SPARE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'(OP_NONE)) |=> (valid_o && !wr_en_o && result_o == $past(operand_i))); // R13
endmodule

bind byte_bitop_unit byte_bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/byte_bitop_unit_tb_top.sv
module byte_bitop_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [2:0] bit_idx_i = '0;
  logic [7:0] operand_i = '0;
  logic [3:0] flags_i = '0;
  logic       valid_o, wr_en_o;
  logic [7:0] result_o;
  logic [3:0] flags_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // held expectations
  int       e_res = 0;
  bit [3:0] e_f = '0;

  always #5 clk_i = ~clk_i;

  byte_bitop_unit dut_i (
    .clk_i, .rst_ni, .valid_i, .op_i, .bit_idx_i, .operand_i, .flags_i,
    .valid_o, .result_o, .wr_en_o, .flags_o
  );

  function automatic string tag_of(int op, bit v);
    if (!v) return "R12";
    case (op)
      0: return "R3 R8";  1, 3: return "R4 R8";  2: return "R2 R8";
      4: return "R5 R8";  5, 7: return "R6 R8";  6: return "R7 R8";
      8: return "R10";    9, 10: return "R11";
      11: return "R3 R9"; 12, 14: return "R4 R9"; 13: return "R2 R9";
      default: return "R13";
    endcase
  endfunction

  task automatic check(string tag, bit ev, int er, bit ew, bit [3:0] ef);
    n_cmp++;
    if (valid_o !== ev || result_o !== er[7:0] || wr_en_o !== ew || flags_o !== ef) begin
      n_bad++;
      $display("FAIL %s: got v=%0b r=%02h w=%0b f=%04b expected v=%0b r=%02h w=%0b f=%04b",
               tag, valid_o, result_o, wr_en_o, flags_o, ev, er[7:0], ew, ef);
    end
  endtask

  task automatic step(bit v, int op, int idx, int x, bit [3:0] f);
    int c, co, r, b, p;
    bit w;
    bit [3:0] fo;
    valid_i = v; op_i = op[3:0]; bit_idx_i = idx[2:0]; operand_i = x[7:0]; flags_i = f;
    c = f[0]; co = c; r = x; w = 1; fo = f;
    p = 1 << idx; b = (x / p) % 2;
    case (op)
      0, 11: begin co = x / 128; r = (x * 2) % 256 + co; end
      1, 12: begin co = x % 2; r = x / 2 + co * 128; end
      2, 13: begin co = x / 128; r = (x * 2) % 256 + c; end
      3, 14: begin co = x % 2; r = x / 2 + c * 128; end
      4: begin co = x / 128; r = (x * 2) % 256; end
      5: begin co = x % 2; r = x / 2 + (x / 128) * 128; end
      6: begin co = 0; r = (x % 16) * 16 + x / 16; end
      7: begin co = x % 2; r = x / 2; end
      8: begin w = 0; fo = {b == 0, 1'b0, 1'b1, f[0]}; end
      9: r = x - b * p;
      10: r = x + (1 - b) * p;
      default: w = 0;
    endcase
    if (op <= 7 || (op >= 11 && op <= 14))
      fo = {(op <= 7) && (r == 0), 1'b0, 1'b0, co[0]};
    if (v) begin e_res = r; e_f = fo; end
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag_of(op, v), v, e_res, v & w, e_f);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", 0, 0, 0, 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // directed corners
    step(1, 2, 0, 8'h80, 4'b0000);   // R2 carry out, zero result
    step(1, 2, 0, 8'h01, 4'b0001);   // R2 carry in lands at bit 0
    step(1, 0, 0, 8'h81, 4'b0000);   // R3
    step(1, 1, 0, 8'h01, 4'b0000);   // R4
    step(1, 3, 0, 8'h00, 4'b0001);   // R4 carry into bit 7
    step(1, 4, 0, 8'hC3, 4'b1111);   // R5
    step(1, 5, 0, 8'h81, 4'b0000);   // R6 sign kept
    step(1, 7, 0, 8'h81, 4'b0000);   // R6 zero fill
    step(1, 6, 0, 8'h00, 4'b0001);   // R7 zero swap, C cleared, R8
    step(1, 6, 0, 8'h3C, 4'b0001);   // R7
    step(1, 13, 0, 8'h00, 4'b0000);  // R9 zero result yet Z clear
    step(1, 11, 0, 8'h80, 4'b1000);  // R9
    step(0, 6, 0, 8'hFF, 4'b1111);   // R12 idle holds
    step(1, 8, 0, 8'hFE, 4'b0001);   // R10 index 0 rightmost
    step(1, 8, 7, 8'h80, 4'b0000);   // R10 index 7 leftmost
    step(1, 9, 7, 8'hFF, 4'b1010);   // R11
    step(1, 10, 0, 8'h00, 4'b0101);  // R11
    step(1, 15, 3, 8'h5A, 4'b1100);  // R13
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, $urandom % 16, $urandom % 8, $urandom % 256, 4'($urandom % 16));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule